// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the host side of an in-system programmer. It brings a target microcontroller into its SPI-based serial programming mode. After a start command it takes the target reset line and holds SCK low. If the bench or board cannot promise that SCK stayed low while the target powered up, it first gives RESET a high pulse. It then waits a settling time and shifts the four-byte programming-enable instruction out on MOSI while it samples MISO.

While the third byte is shifted, a target that is in step returns the second instruction byte (0x53) on MISO. The sequencer always sends all four bytes and then judges that echo. A good echo leaves the target held in reset with a ready flag raised. A bad echo causes another RESET pulse, a new settling wait and a fresh instruction. After a fixed number of failed attempts the block raises a failure flag and lets go of every pin.

All timing is given as system-clock counts on input ports: the reset pulse width, the settling wait (20 ms of real time in practice) and the SCK half-period. A test setup can therefore make them short.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset, and while idle, `rst_oe`, `rst_drv`, `sck`, `mosi`, `busy`, `ready` and `failed` are all 0. Here `rst_oe`=1 means the block drives the target RESET line, and `rst_drv` is the level it drives.
- R2: A start accepted with `sck_unsure`=1 first drives RESET high (`rst_oe`=1, `rst_drv`=1) for exactly `pulse_len` clock cycles, with SCK low. With `sck_unsure`=0 there is no such pulse.
- R3: From the cycle RESET is driven low (start, or the end of a pulse), SCK stays low for exactly `settle_len` + `half_len` cycles before its first rising edge.
- R4: Every SCK high phase lasts `half_len` cycles, and so does every low phase between bits. SCK is high only while `busy`=1. MOSI never changes while SCK is high (mode 0: data set while SCK is low, taken on the rising edge).
- R5: Each attempt sends exactly 32 bits, MSB first: 0xAC, 0x53, 0x00, 0x00. All four bytes are sent even when the echo is wrong.
- R6: MISO is sampled on the rising SCK edges of the third byte (bits 16..23). The attempt succeeds only if those 8 bits, MSB first, equal 0x53. A single wrong bit makes it fail.
- R7: After a failed attempt, RESET is driven high for `pulse_len` cycles and then low again (never released). The settling wait and a full new instruction follow.
- R8: When `MAX_TRIES` attempts have all failed, `failed`=1 and `busy`=0, and `rst_oe`, `sck` and `mosi` are 0. No pulse follows the last attempt.
- R9: After a good echo, `ready`=1 and `busy`=0, and the target stays held in reset (`rst_oe`=1, `rst_drv`=0) with SCK low until the next start. At most one of `busy`, `ready` and `failed` is 1.
- R10: `start` is ignored while `busy`=1. The attempt count and the bit stream are unchanged.
- R11: A start from the ready or failed state begins a new sequence with the attempt count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the entry sequence (taken when not busy) |
| sck_unsure | input | 1 | 1: give RESET a high pulse before the first attempt |
| pulse_len | input | CW | RESET high pulse width in clocks (0 acts as 1) |
| settle_len | input | CW | Wait after RESET goes low, in clocks (0 acts as 1) |
| half_len | input | CW | SCK half-period in clocks (0 acts as 1) |
| miso | input | 1 | Serial data from the target |
| rst_oe | output | 1 | 1: the target RESET line is driven |
| rst_drv | output | 1 | Level driven on RESET when `rst_oe`=1 |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Target entered programming mode |
| failed | output | 1 | Attempt limit reached, pins released |

## Verification
A wrong bit counter or byte index shows up within one instruction: the 32-bit stream that a target model receives would differ from 0xAC530000, or it would have a different length. A broken echo capture or retry counter shows up when the sequence ends. The flag would be wrong, or the number of RESET pulses would differ from the number of bad echoes the model was told to give, swept from zero up to the attempt limit. Timer faults show up on the very next phase as a wrong pulse width, settling gap or SCK half-period. The bench measures each of these against the configured counts.

// File: rtl/prog_entry_pkg.sv
// Shared constants, state encoding and instruction lookup for the
// serial programming entry sequencer. Assumes a four-byte instruction
// whose echo is checked in the third byte.
package prog_entry_pkg;
    localparam int          INSTR_BYTES = 4;
    localparam int          ECHO_IDX    = 2;
    localparam logic [7:0]  ECHO_VAL    = 8'h53;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SETTLE,
        ST_LOW,
        ST_HIGH,
        ST_READY,
        ST_FAIL
    } seq_state_t;

    // Byte of the programming-enable instruction at position idx.
    function automatic logic [7:0] instr_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'hAC;
            2'd1:    return 8'h53;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/prog_phase_timer.sv
// Down-counter for one timed phase. A load starts a phase of len cycles.
// done is high in the last cycle of the phase. Assumes the caller loads
// it on the same edge that enters the phase; len of 0 behaves as 1.
module prog_phase_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/prog_echo_cap.sv
// Captures the MISO bits sampled during the echo byte of the instruction
// and compares them with the expected echo. Assumes bit_idx counts the
// instruction bits from 0, MSB first, and sample marks a rising SCK edge.
module prog_echo_cap
    import prog_entry_pkg::*;
#(
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic [BW-1:0] bit_idx,
    input  logic          miso,
    output logic          match
);
    logic [7:0] cap;
    logic       in_echo;

    assign in_echo = (int'(bit_idx[BW-1:3]) == ECHO_IDX);

    // Shift in MISO on rising edges that fall inside the echo byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap <= '0;
        else if (clear)
            cap <= '0;
        else if (sample && in_echo)
            cap <= {cap[6:0], miso};
    end

    assign match = (cap == ECHO_VAL);
endmodule

// File: rtl/prog_entry_seq.sv
// Serial programming entry sequencer. On start it holds the target in
// reset, optionally gives RESET a high pulse, waits a settling time and
// then shifts the four-byte enable instruction in SPI mode 0 while it
// checks the echo in the third byte. It retries after a bad echo, up to
// MAX_TRIES attempts. All delays are clock counts taken from the ports.
// Assumes the counts are held stable while busy.
module prog_entry_seq
    import prog_entry_pkg::*;
#(
    parameter int CW        = 24,
    parameter int MAX_TRIES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sck_unsure,
    input  logic [CW-1:0] pulse_len,
    input  logic [CW-1:0] settle_len,
    input  logic [CW-1:0] half_len,
    input  logic          miso,
    output logic          rst_oe,
    output logic          rst_drv,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic          ready,
    output logic          failed
);
    localparam int NBITS = 8 * INSTR_BYTES;
    localparam int BW    = $clog2(NBITS);
    localparam int TW    = $clog2(MAX_TRIES + 1);

    seq_state_t    state, nxt;
    logic [BW-1:0] bit_idx, nbit;
    logic [TW-1:0] tries;
    logic          ld, done, match, start_acc, retry, last_bit, next_mosi;
    logic [CW-1:0] ld_len;
    logic [7:0]    cur_byte;

    prog_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .len   (ld_len),
        .done  (done)
    );

    prog_echo_cap #(.BW(BW)) u_echo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ld && (nxt == ST_PULSE || nxt == ST_SETTLE)),
        .sample  (state == ST_LOW && done),
        .bit_idx (bit_idx),
        .miso    (miso),
        .match   (match)
    );

    assign last_bit  = (bit_idx == BW'(NBITS - 1));
    assign start_acc = start && (state == ST_IDLE || state == ST_READY || state == ST_FAIL);
    assign nbit      = (state == ST_HIGH) ? bit_idx + 1'b1 : '0;
    assign cur_byte  = instr_byte(nbit[BW-1:3]);
    assign next_mosi = cur_byte[3'd7 - nbit[2:0]];

    // Next-state choice and phase timer loading.
    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ld_len = half_len;
        retry  = 1'b0;
        case (state)
            ST_IDLE, ST_READY, ST_FAIL: begin
                if (start) begin
                    ld     = 1'b1;
                    nxt    = sck_unsure ? ST_PULSE : ST_SETTLE;
                    ld_len = sck_unsure ? pulse_len : settle_len;
                end
            end
            ST_PULSE: if (done) begin
                ld = 1'b1; nxt = ST_SETTLE; ld_len = settle_len;
            end
            ST_SETTLE: if (done) begin
                ld = 1'b1; nxt = ST_LOW;
            end
            ST_LOW: if (done) begin
                ld = 1'b1; nxt = ST_HIGH;
            end
            ST_HIGH: if (done) begin
                if (!last_bit) begin
                    ld = 1'b1; nxt = ST_LOW;
                end else if (match) begin
                    nxt = ST_READY;
                end else if (tries == TW'(MAX_TRIES - 1)) begin
                    nxt = ST_FAIL;
                end else begin
                    ld = 1'b1; nxt = ST_PULSE; ld_len = pulse_len; retry = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, bit position, attempt count and serial data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            tries   <= '0;
            mosi    <= 1'b0;
        end else begin
            state <= nxt;
            if (start_acc)
                tries <= '0;
            else if (retry)
                tries <= tries + 1'b1;
            if (ld && nxt == ST_LOW) begin
                bit_idx <= nbit;
                mosi    <= next_mosi;
            end else if (nxt != ST_LOW && nxt != ST_HIGH) begin
                bit_idx <= '0;
                mosi    <= 1'b0;
            end
        end
    end

    // Pin and flag decode from the state register.
    always_comb begin
        rst_oe  = !(state == ST_IDLE || state == ST_FAIL);
        rst_drv = (state == ST_PULSE);
        sck     = (state == ST_HIGH);
        busy    = (state == ST_PULSE || state == ST_SETTLE ||
                   state == ST_LOW   || state == ST_HIGH);
        ready   = (state == ST_READY);
        failed  = (state == ST_FAIL);
    end
endmodule

// File: rtl/prog_entry_chk.sv
// Property checker for the entry sequencer, bound to every instance.
// Observes only the ports; assumes a synchronous active-low reset.
module prog_entry_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_oe,
    input logic rst_drv,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic ready,
    input logic failed
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready) |-> (!rst_oe && !sck && !rst_drv));

    // R2
    pulse_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_drv |-> (rst_oe && !sck));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    // R4
    sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy);

    // R7
    pulse_end_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drv) |-> (rst_oe && !sck));

    // R8
    fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (!rst_oe && !sck && !mosi));

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rst_oe && !rst_drv && !sck));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, ready, failed}));
endmodule

bind prog_entry_seq prog_entry_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_oe  (rst_oe),
    .rst_drv (rst_drv),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (busy),
    .ready   (ready),
    .failed  (failed)
);

// File: tb/sim_prog_entry_seq.sv
// Bench: a target model answers on MISO with a correct or a corrupted
// echo, and measures pulse widths, gaps, half-periods and the bit stream.
module sim_prog_entry_seq;
    localparam int CW    = 8;
    localparam int MAXT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sck_unsure = 1'b0;
    logic [CW-1:0] pulse_len = 8'd1, settle_len = 8'd1, half_len = 8'd1;
    logic miso = 1'b0;
    logic rst_oe, rst_drv, sck, mosi, busy, ready, failed;

    int checks = 0, errors = 0, cyc = 0;
    bit wd_hit = 1'b0;

    // target model / measurement state
    int  cur_pulse = 1, cur_settle = 1, cur_half = 1, fcnt = 0;
    int  bitpos = 0, attempts = 0, attempt_idx = 0, pulses = 0, rises_total = 0;
    int  pw = 0, hi_run = 0, lo_run = 0, gap = 0;
    int  bad_bytes = 0, bad_pw = 0, bad_gap = 0, bad_half = 0, bad_mosi = 0;
    logic [31:0] rxw = '0;
    logic [7:0]  echo;
    logic prev_sck = 1'b0, prev_drv = 1'b0, prev_mosi = 1'b0;

    always #5 clk = ~clk;

    prog_entry_seq #(.CW(CW), .MAX_TRIES(MAXT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sck_unsure(sck_unsure),
        .pulse_len(pulse_len), .settle_len(settle_len), .half_len(half_len),
        .miso(miso), .rst_oe(rst_oe), .rst_drv(rst_drv), .sck(sck),
        .mosi(mosi), .busy(busy), .ready(ready), .failed(failed)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Target model and port measurements, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_drv) pw++;
            if (!prev_drv && rst_drv) pulses++;
            if (prev_drv && !rst_drv) begin
                if (pw != cur_pulse) bad_pw++;
                pw = 0;
            end
            if (!busy || rst_drv) begin
                bitpos = 0; rxw = '0; gap = 0;
            end
            if (sck && prev_sck && mosi != prev_mosi) bad_mosi++;
            if (sck && !prev_sck) begin
                if (bitpos == 0) begin
                    if (gap != cur_settle + cur_half) bad_gap++;
                end else if (lo_run != cur_half) bad_half++;
                rxw = {rxw[30:0], mosi};
                bitpos++;
                rises_total++;
                hi_run = 1;
                if (bitpos == 32) begin
                    attempts++;
                    if (rxw != 32'hAC530000) bad_bytes++;
                    attempt_idx++;
                end
            end else if (sck) begin
                hi_run++;
            end
            if (!sck && prev_sck) begin
                if (hi_run != cur_half) bad_half++;
                lo_run = 1;
                echo = (attempt_idx < fcnt) ? (8'h53 ^ (8'h80 >> (attempt_idx % 8))) : 8'h53;
                if (bitpos >= 16 && bitpos < 24) miso = echo[23 - bitpos];
                else miso = 1'b0;
            end else if (!sck) begin
                lo_run++;
                if (bitpos == 0 && busy && !rst_drv) gap++;
            end
            prev_sck = sck; prev_drv = rst_drv; prev_mosi = mosi;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            wd_hit = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input int us, input int f, input int pl,
                            input int sl, input int hl, input bit poke);
        bit poked = 1'b0;
        bit exp_ok;
        int exp_att, exp_pul;
        sck_unsure = us[0];
        pulse_len = CW'(pl); settle_len = CW'(sl); half_len = CW'(hl);
        cur_pulse = pl; cur_settle = sl; cur_half = hl; fcnt = f;
        attempts = 0; attempt_idx = 0; pulses = 0; rises_total = 0;
        bad_bytes = 0; bad_pw = 0; bad_gap = 0; bad_half = 0; bad_mosi = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(ready || failed) && !wd_hit) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && !poked && rises_total >= 10) begin
                start = 1'b1; poked = 1'b1;
            end
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        exp_ok  = (f < MAXT);
        exp_att = exp_ok ? f + 1 : MAXT;
        exp_pul = us + exp_att - 1;
        // R6 R9 R8: outcome follows the echo seen in the third byte
        chk(ready == exp_ok && failed == !exp_ok, "R6", "ready flag", int'(ready), int'(exp_ok));
        // R5 R7 R10 R11: one full instruction per attempt, count restarts
        chk(attempts == exp_att, "R7", "attempts", attempts, exp_att);
        // R2 R7: pulse count
        chk(pulses == exp_pul, "R2", "reset pulses", pulses, exp_pul);
        // R5: instruction bytes
        chk(bad_bytes == 0, "R5", "bad instruction streams", bad_bytes, 0);
        chk(bad_pw == 0, "R7", "bad pulse widths", bad_pw, 0);
        chk(bad_gap == 0, "R3", "bad settle gaps", bad_gap, 0);
        chk(bad_half == 0 && bad_mosi == 0, "R4", "bad sck phases or mosi moves",
            bad_half + bad_mosi, 0);
        if (exp_ok)
            // R9: target held in reset after success
            chk(rst_oe && !rst_drv && !sck && !busy, "R9", "held state",
                int'({rst_oe, rst_drv, sck, busy}), 8);
        else
            // R8: pins released after the limit
            chk(!rst_oe && !sck && !mosi && !busy, "R8", "released state",
                int'({rst_oe, sck, mosi, busy}), 0);
        if (poke)
            // R10: the mid-run start left the stream intact
            chk(rises_total == 32 * exp_att, "R10", "total sck rises",
                rises_total, 32 * exp_att);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({rst_oe, rst_drv, sck, mosi, busy, ready, failed} == 7'd0, "R1",
            "outputs in reset", int'({rst_oe, rst_drv, sck, mosi, busy, ready, failed}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({rst_oe, rst_drv, sck, mosi, busy, ready, failed} == 7'd0, "R1",
            "outputs idle", int'({rst_oe, rst_drv, sck, mosi, busy, ready, failed}), 0);
        for (int us = 0; us < 2; us++)
            for (int pi = 0; pi < 2; pi++)
                for (int si = 0; si < 2; si++)
                    for (int hi = 0; hi < 2; hi++)
                        for (int f = 0; f <= MAXT; f++)
                            run_case(us, f, 1 + 2 * pi, 1 + 4 * si, 1 + 2 * hi, f == 2);
        // R11: a failed run followed by a good one starts a fresh count
        run_case(0, MAXT, 2, 2, 2, 1'b0);
        run_case(1, MAXT - 1, 2, 2, 2, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule